// File: doc/BRIEF.md
# CAN Protocol Error Classifier

This block sits beside a CAN or CAN FD bit-stream sequencer and sorts bit-level faults into six classes: stuff, form, acknowledge, bit1, bit0 and CRC. The sequencer supplies the node's transmitted bit, the bus bit and per-bit position flags. These flags mark the arbitration field, the stuffed region, fixed-format bits, the acknowledge slot, the FD data phase and a CRC mismatch. The classifier combines them with the two bit values at each sample point. It keeps the most recent error in one of two 3-bit status fields. One field is for the arbitration phase, or the whole of a classic frame. The other is for the FD data phase.

In the data phase the transmitter's own bit is checked against the bus at a secondary sample point. That point falls a programmable number of clock cycles after the start of the bit, which compensates for transceiver loop delay. Each recorded error also produces a one-cycle pulse carrying the code and the phase, so that an error-frame generator or fault counters can react. Software reads a field by pulsing its read strobe. The field then shows "unchanged since read" until the next error arrives.

Top module: `can_err_classifier`

## Requirements
- R1: With `in_stuffed` high at a sample point, a bus bit that is the sixth or later equal bit in a row inside the stuffed region raises code 1 (stuff). The run count restarts whenever a sample point arrives with `in_stuffed` low.
- R2: Outside the data phase, when transmitting, a driven 1 sampled as 0 raises code 4 (bit1). This does not apply inside the arbitration field, where it is lost arbitration and records nothing. It also does not apply in the acknowledge slot.
- R3: Outside the data phase, when transmitting, a driven 0 sampled as 1 raises code 5 (bit0).
- R4: When transmitting, a recessive (1) bus value in the acknowledge slot raises code 3 (ack).
- R5: A dominant (0) bus value on a bit flagged fixed-format raises code 2 (form).
- R6: `crc_bad` high at a sample point raises code 6 (CRC).
- R7: An error found with `data_phase` low goes to `arb_code`. An error found with `data_phase` high goes to `data_code`. The other field keeps its value.
- R8: In the data phase, while transmitting, the bit check uses the bus value in the cycle `tdc_offset` clock cycles after `bit_start` (offset at least 1). It compares that value with the transmit bit captured at `bit_start`, and the result goes to `data_code`. The sample-point bit check is off in the data phase.
- R9: When several errors occur at one evaluation, exactly one is recorded, in this order of precedence: bit1/bit0, then stuff, form, CRC, ack. A secondary-point bit error beats any sample-point error in the same cycle.
- R10: Both fields reset to 0 (none). A read strobe sets its field to 7 (unchanged since read) on the next cycle, unless an error is written to that field in the same cycle, in which case the error code is stored.
- R11: `err_pulse` is high for one cycle, the cycle after the evaluation that found the error. In that cycle `err_code` holds the recorded code and `err_in_data` holds 1 for the data-phase field.
- R12: With no error and no read, `err_pulse` stays low and both fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_start | input | 1 | Pulse at the first clock cycle of a bit |
| sample_pt | input | 1 | Pulse at the nominal sample point of a bit |
| tx_bit | input | 1 | Bit the node drives (1 recessive) |
| rx_bit | input | 1 | Bit monitored on the bus |
| transmitting | input | 1 | Node is the transmitter of the current frame |
| in_arb | input | 1 | Current bit is in the arbitration field |
| in_stuffed | input | 1 | Current bit is in a stuffed region |
| fixed_form | input | 1 | Current bit is a fixed-format (recessive) bit |
| ack_slot | input | 1 | Current bit is the acknowledge slot |
| data_phase | input | 1 | Current bit is in the FD data phase |
| crc_bad | input | 1 | Checksum mismatch, valid with sample_pt |
| tdc_offset | input | OFS_W | Secondary sample point, cycles after bit_start |
| rd_arb | input | 1 | Read strobe for arb_code |
| rd_data | input | 1 | Read strobe for data_code |
| arb_code | output | 3 | Last error, arbitration phase or classic frame |
| data_code | output | 3 | Last error, FD data phase |
| err_pulse | output | 1 | One-cycle error indication |
| err_code | output | 3 | Code accompanying err_pulse |
| err_in_data | output | 1 | Error accompanying err_pulse is a data-phase error |

## Verification
Each error class is triggered on its own with the other position flags held quiet. This separates a wrong code from a wrong qualifying flag. The case of recessive driven and dominant seen is tried both in and out of the arbitration field, so that lost arbitration is shown to stay silent. Runs of five, six and seven equal bits are sent, along with a run broken by leaving the stuffed region, to pin down the stuff threshold and its restart. Data-phase bits carry a bus glitch placed either exactly at the secondary point or one cycle before it, which shows that the compare uses the offset. Stacked error conditions check the precedence order.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  typedef enum logic [2:0] {
    EC_NONE   = 3'd0,
    EC_STUFF  = 3'd1,
    EC_FORM   = 3'd2,
    EC_ACK    = 3'd3,
    EC_BIT1   = 3'd4,
    EC_BIT0   = 3'd5,
    EC_CRC    = 3'd6,
    EC_UNREAD = 3'd7
  } err_code_e;
endpackage

// File: rtl/can_ssp_tap.sv
module can_ssp_tap
  import can_err_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_start,
  input  logic             enable,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic [OFS_W-1:0] tdc_offset,
  output err_code_e        ssp_code
);
  localparam logic [OFS_W-1:0] CNT_MAX = {OFS_W{1'b1}};

  logic [OFS_W-1:0] cnt;
  logic             armed;
  logic             tx_lat;
  logic             hit;

  // compare point: cnt counts cycles elapsed since the bit_start cycle
  assign hit = armed && !bit_start && (cnt == tdc_offset);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      armed  <= 1'b0;
      tx_lat <= 1'b1;
    end else if (bit_start) begin
      cnt    <= {{(OFS_W-1){1'b0}}, 1'b1};
      armed  <= 1'b1;
      tx_lat <= tx_bit;
    end else begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (hit) armed <= 1'b0;
    end
  end

  always_comb begin
    ssp_code = EC_NONE;
    if (hit && enable) begin
      if (tx_lat && !rx_bit)      ssp_code = EC_BIT1;
      else if (!tx_lat && rx_bit) ssp_code = EC_BIT0;
    end
  end

  // R8: at most one secondary compare per bit
  p_ssp_once_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && !bit_start) |=> !hit);
endmodule

// File: rtl/can_sp_check.sv
module can_sp_check
  import can_err_pkg::*;
#(
  parameter int STUFF_LIMIT = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sample_pt,
  input  logic      tx_bit,
  input  logic      rx_bit,
  input  logic      transmitting,
  input  logic      in_arb,
  input  logic      in_stuffed,
  input  logic      fixed_form,
  input  logic      ack_slot,
  input  logic      data_phase,
  input  logic      crc_bad,
  output err_code_e sp_code
);
  localparam int RW = $clog2(STUFF_LIMIT + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_LIMIT + 1);
  localparam logic [RW-1:0] RUN_LIM = RW'(STUFF_LIMIT);

  logic [RW-1:0] run;
  logic          last_rx;
  logic          same;
  logic          chk_bits;
  logic          e_bit1, e_bit0, e_stuff, e_form, e_crc, e_ack;

  assign same     = (run != '0) && (rx_bit == last_rx);
  assign chk_bits = sample_pt && transmitting && !data_phase;
  assign e_bit1   = chk_bits && tx_bit && !rx_bit && !in_arb && !ack_slot;
  assign e_bit0   = chk_bits && !tx_bit && rx_bit;
  assign e_stuff  = sample_pt && in_stuffed && same && (run >= RUN_LIM);
  assign e_form   = sample_pt && fixed_form && !rx_bit;
  assign e_crc    = sample_pt && crc_bad;
  assign e_ack    = sample_pt && transmitting && ack_slot && rx_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      last_rx <= 1'b1;
    end else if (sample_pt) begin
      if (in_stuffed) begin
        last_rx <= rx_bit;
        if (same) run <= (run == RUN_MAX) ? RUN_MAX : run + 1'b1;
        else      run <= {{(RW-1){1'b0}}, 1'b1};
      end else begin
        run <= '0;
      end
    end
  end

  always_comb begin
    if (e_bit1)       sp_code = EC_BIT1;
    else if (e_bit0)  sp_code = EC_BIT0;
    else if (e_stuff) sp_code = EC_STUFF;
    else if (e_form)  sp_code = EC_FORM;
    else if (e_crc)   sp_code = EC_CRC;
    else if (e_ack)   sp_code = EC_ACK;
    else              sp_code = EC_NONE;
  end

  // R2: recessive overwritten in arbitration is lost arbitration, not bit1
  p_arb_loss_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (sample_pt && transmitting && in_arb && tx_bit && !rx_bit) |-> (sp_code != EC_BIT1));
  // R1: a stuff code only comes from inside a stuffed region
  p_stuff_region_r1: assert property (@(posedge clk) disable iff (rst)
    (sp_code == EC_STUFF) |-> in_stuffed);
  // R8: no sample-point bit errors in the data phase
  p_dp_no_sp_bit_r8: assert property (@(posedge clk) disable iff (rst)
    data_phase |-> (sp_code != EC_BIT1 && sp_code != EC_BIT0));
endmodule

// File: rtl/can_err_record.sv
module can_err_record
  import can_err_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  logic      wr_dp,
  input  err_code_e wr_code,
  input  logic      rd_arb,
  input  logic      rd_data,
  output err_code_e arb_code,
  output err_code_e data_code,
  output logic      err_pulse,
  output err_code_e err_code,
  output logic      err_in_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      arb_code    <= EC_NONE;
      data_code   <= EC_NONE;
      err_pulse   <= 1'b0;
      err_code    <= EC_NONE;
      err_in_data <= 1'b0;
    end else begin
      err_pulse <= wr;
      if (wr) begin
        err_code    <= wr_code;
        err_in_data <= wr_dp;
      end
      if (wr && !wr_dp) arb_code  <= wr_code;
      else if (rd_arb)  arb_code  <= EC_UNREAD;
      if (wr && wr_dp)  data_code <= wr_code;
      else if (rd_data) data_code <= EC_UNREAD;
    end
  end

  // R10: a read with no concurrent write marks the field unread
  p_read_marks_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_arb && !(wr && !wr_dp)) |=> (arb_code == EC_UNREAD));
  // R12: quiet cycles leave the fields alone
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!wr && !rd_arb && !rd_data) |=> ($stable(arb_code) && $stable(data_code)));
  // R11: a pulse always carries a real error class
  p_pulse_code_r11: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_code != EC_NONE && err_code != EC_UNREAD));
endmodule

// File: rtl/can_err_classifier.sv
module can_err_classifier
  import can_err_pkg::*;
#(
  parameter int OFS_W       = 6,
  parameter int STUFF_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_start,
  input  logic             sample_pt,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic             transmitting,
  input  logic             in_arb,
  input  logic             in_stuffed,
  input  logic             fixed_form,
  input  logic             ack_slot,
  input  logic             data_phase,
  input  logic             crc_bad,
  input  logic [OFS_W-1:0] tdc_offset,
  input  logic             rd_arb,
  input  logic             rd_data,
  output logic [2:0]       arb_code,
  output logic [2:0]       data_code,
  output logic             err_pulse,
  output logic [2:0]       err_code,
  output logic             err_in_data
);
  err_code_e ssp_code, sp_code, sel_code;
  err_code_e arb_q, data_q, pulse_q;
  logic      ssp_err, wr, wr_dp;

  can_ssp_tap #(.OFS_W(OFS_W)) u_ssp (
    .clk(clk), .rst(rst), .bit_start(bit_start),
    .enable(data_phase && transmitting),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .tdc_offset(tdc_offset),
    .ssp_code(ssp_code)
  );

  can_sp_check #(.STUFF_LIMIT(STUFF_LIMIT)) u_sp (
    .clk(clk), .rst(rst), .sample_pt(sample_pt),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .transmitting(transmitting),
    .in_arb(in_arb), .in_stuffed(in_stuffed), .fixed_form(fixed_form),
    .ack_slot(ack_slot), .data_phase(data_phase), .crc_bad(crc_bad),
    .sp_code(sp_code)
  );

  assign ssp_err  = (ssp_code != EC_NONE);
  assign sel_code = ssp_err ? ssp_code : sp_code;
  assign wr       = ssp_err || (sp_code != EC_NONE);
  assign wr_dp    = ssp_err || data_phase;

  can_err_record u_rec (
    .clk(clk), .rst(rst), .wr(wr), .wr_dp(wr_dp), .wr_code(sel_code),
    .rd_arb(rd_arb), .rd_data(rd_data),
    .arb_code(arb_q), .data_code(data_q),
    .err_pulse(err_pulse), .err_code(pulse_q), .err_in_data(err_in_data)
  );

  assign arb_code  = arb_q;
  assign data_code = data_q;
  assign err_code  = pulse_q;

  // R7: the pulsed code lands in the field named by err_in_data
  p_route_data_r7: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && err_in_data) |-> (data_code == err_code));
  p_route_arb_r7: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && !err_in_data) |-> (arb_code == err_code));
  // R9: a secondary-point bit error always wins the cycle
  p_ssp_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ssp_err |=> (err_pulse && (err_code == 3'd4 || err_code == 3'd5)));
endmodule

// File: tb/can_err_classifier_tb.sv
`timescale 1ns/1ps
module can_err_classifier_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_start = 0, sample_pt = 0, tx_bit = 1, rx_bit = 1;
  logic transmitting = 0, in_arb = 0, in_stuffed = 0, fixed_form = 0;
  logic ack_slot = 0, data_phase = 0, crc_bad = 0, rd_arb = 0, rd_data = 0;
  logic [5:0] tdc_offset = 6'd3;
  logic [2:0] arb_code, data_code, err_code;
  logic err_pulse, err_in_data;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  can_err_classifier u_dut (
    .clk(clk), .rst(rst), .bit_start(bit_start), .sample_pt(sample_pt),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .transmitting(transmitting),
    .in_arb(in_arb), .in_stuffed(in_stuffed), .fixed_form(fixed_form),
    .ack_slot(ack_slot), .data_phase(data_phase), .crc_bad(crc_bad),
    .tdc_offset(tdc_offset), .rd_arb(rd_arb), .rd_data(rd_data),
    .arb_code(arb_code), .data_code(data_code), .err_pulse(err_pulse),
    .err_code(err_code), .err_in_data(err_in_data)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: R11 pulse carries code and phase, popped from the scoreboard
  always @(negedge clk) begin
    if (!rst && err_pulse) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12: actual pulse code %0d expected no pulse", err_code);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({err_in_data, err_code} !== e) begin
          errors++;
          $display("FAIL %s/R11: actual %0d expected %0d", t, {err_in_data, err_code}, e);
        end
      end
    end
  end

  task automatic push(input logic dp, input logic [2:0] code, input string tag);
    if (code != 3'd0) begin
      exp_q.push_back({dp, code});
      tag_q.push_back(tag);
    end
  endtask

  // one sample-point evaluation; exp_code 0 means no error expected
  task automatic sp_bit(input logic tx, input logic rx, input logic xm, input logic arb,
                        input logic stf, input logic fx, input logic ak, input logic dp,
                        input logic crc, input logic [2:0] exp_code, input string tag);
    @(negedge clk);
    tx_bit = tx; rx_bit = rx; transmitting = xm; in_arb = arb; in_stuffed = stf;
    fixed_form = fx; ack_slot = ak; data_phase = dp; crc_bad = crc; sample_pt = 1;
    push(dp, exp_code, tag);
    @(negedge clk);
    sample_pt = 0; crc_bad = 0; fixed_form = 0; ack_slot = 0; rd_arb = 0; rd_data = 0;
    tx_bit = 1; rx_bit = 1;
  endtask

  // data-phase bit with offset 3: rx_early at count 2, rx_hit at count 3
  task automatic ssp_bit(input logic tx, input logic rx_early, input logic rx_hit,
                         input logic [2:0] exp_code, input string tag);
    @(negedge clk); data_phase = 1; transmitting = 1; tx_bit = tx; rx_bit = tx; bit_start = 1;
    @(negedge clk); bit_start = 0;
    @(negedge clk); rx_bit = rx_early;
    @(negedge clk); rx_bit = rx_hit; push(1'b1, exp_code, tag);
    @(negedge clk); rx_bit = tx;
    @(negedge clk); data_phase = 0; transmitting = 0; tx_bit = 1; rx_bit = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset arb", {1'b0, arb_code}, 4'd0);
    chk("R10 reset data", {1'b0, data_code}, 4'd0);
    chk("R12 reset pulse", {3'b0, err_pulse}, 4'd0);

    sp_bit(0, 1, 1, 0, 0, 0, 0, 0, 0, 3'd5, "R3");
    chk("R3/R7 arb field", {1'b0, arb_code}, 4'd5);
    sp_bit(1, 0, 1, 1, 0, 0, 0, 0, 0, 3'd0, "R2 arb loss");
    chk("R2 arb loss no pulse", {3'b0, err_pulse}, 4'd0);
    chk("R2 arb loss field held", {1'b0, arb_code}, 4'd5);
    sp_bit(1, 0, 1, 0, 0, 0, 0, 0, 0, 3'd4, "R2");
    chk("R2 bit1 field", {1'b0, arb_code}, 4'd4);
    sp_bit(1, 1, 1, 0, 0, 0, 1, 0, 0, 3'd3, "R4");
    chk("R4 ack field", {1'b0, arb_code}, 4'd3);
    sp_bit(1, 0, 0, 0, 0, 1, 0, 0, 0, 3'd2, "R5");
    chk("R5 form field", {1'b0, arb_code}, 4'd2);
    sp_bit(1, 1, 0, 0, 0, 0, 0, 0, 1, 3'd6, "R6");
    chk("R6 crc field", {1'b0, arb_code}, 4'd6);

    // R1 stuff threshold and restart
    for (int i = 0; i < 5; i++) sp_bit(0, 0, 0, 0, 1, 0, 0, 0, 0, 3'd0, "R1 run");
    chk("R1 five equal quiet", {1'b0, arb_code}, 4'd6);
    sp_bit(0, 0, 0, 0, 1, 0, 0, 0, 0, 3'd1, "R1 sixth");
    sp_bit(0, 0, 0, 0, 1, 0, 0, 0, 0, 3'd1, "R1 seventh");
    for (int i = 0; i < 5; i++) sp_bit(1, 1, 0, 0, 1, 0, 0, 0, 0, 3'd0, "R1 ones");
    sp_bit(1, 1, 0, 0, 0, 0, 0, 0, 0, 3'd0, "R1 leave");
    for (int i = 0; i < 5; i++) sp_bit(1, 1, 0, 0, 1, 0, 0, 0, 0, 3'd0, "R1 restart");
    chk("R1 restart quiet", {1'b0, arb_code}, 4'd1);
    sp_bit(1, 1, 0, 0, 1, 0, 0, 0, 0, 3'd1, "R1 after restart");
    sp_bit(1, 1, 0, 0, 0, 0, 0, 0, 0, 3'd0, "R1 exit");

    // R10 read marks unread; read plus error keeps the error
    @(negedge clk); rd_arb = 1;
    @(negedge clk); rd_arb = 0;
    chk("R10 read arb", {1'b0, arb_code}, 4'd7);
    rd_arb = 1;
    sp_bit(1, 0, 0, 0, 0, 1, 0, 0, 0, 3'd2, "R10 read+err");
    chk("R10 error beats read", {1'b0, arb_code}, 4'd2);
    @(negedge clk); rd_arb = 1;
    @(negedge clk); rd_arb = 0;

    // R7 data-phase routing
    sp_bit(1, 0, 0, 0, 0, 1, 0, 1, 0, 3'd2, "R7 dp form");
    chk("R7 data field", {1'b0, data_code}, 4'd2);
    chk("R7 arb untouched", {1'b0, arb_code}, 4'd7);

    // R8 secondary sample point
    ssp_bit(1, 1, 0, 3'd4, "R8 hit");
    chk("R8 data bit1", {1'b0, data_code}, 4'd4);
    ssp_bit(0, 1, 0, 3'd0, "R8 early glitch");
    chk("R8 early glitch ignored", {1'b0, data_code}, 4'd4);
    sp_bit(1, 0, 1, 0, 0, 0, 0, 1, 0, 3'd0, "R8 sp off");
    chk("R8 sp compare off", {1'b0, data_code}, 4'd4);
    @(negedge clk); rd_data = 1;
    @(negedge clk); rd_data = 0;
    chk("R10 read data", {1'b0, data_code}, 4'd7);

    // R9 precedence
    for (int i = 0; i < 5; i++) sp_bit(0, 0, 1, 0, 1, 0, 0, 0, 0, 3'd0, "R9 prep");
    sp_bit(1, 0, 1, 0, 1, 1, 0, 0, 1, 3'd4, "R9 bit first");
    sp_bit(1, 0, 0, 0, 1, 1, 0, 0, 1, 3'd1, "R9 stuff over form");
    sp_bit(1, 0, 0, 0, 0, 1, 0, 0, 1, 3'd2, "R9 form over crc");
    sp_bit(1, 1, 1, 0, 0, 0, 1, 0, 1, 3'd6, "R9 crc over ack");
    chk("R9 final field", {1'b0, arb_code}, 4'd6);

    @(negedge clk);
    chk("R12 quiet pulse", {3'b0, err_pulse}, 4'd0);
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11: actual %0d missing pulses expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule